// File: doc/BRIEF.md
# Lag-Aware SPI ADC Channel Sequencer

This block drives a multichannel successive-approximation converter over SPI. The converter has one quirk: the sample returned during a frame was converted with the configuration that was loaded two frames before. A host asks for one channel at a time through a valid/ready handshake. The block then issues exactly the frames needed to get a sample that belongs to that channel. It returns the sample with a one-cycle done pulse.

The block keeps a 14-bit shadow of the converter's configuration word. A channel request rewrites only the 3-bit channel field of that shadow. The host may also replace the whole word with a raw write. The block remembers which channel it last read. If the request names the same channel, one configuration frame and one all-zero capture frame are enough. If the channel changed, the configuration is sent twice before the capture frame. Every frame is followed by an idle gap of at least GAP_NS on the chip select. After reset, the block loads a fixed start-up configuration and performs two dummy reads of channel 0. Only then does it accept host requests.

Top module: `adcseq`

## Requirements
- R1: While reset is held and right after it is released, csN is 1, sclk is 0, done and err are 0, busy is 0, and reqReady is 0 because start-up has not finished.
- R2: After reset the block sends, unrequested, five frames: the configuration 14'h3C79, then two reads of channel 0 (each one configuration frame plus one capture frame). No done pulse is raised during these frames. reqReady rises only after all five.
- R3: A frame holds csN low for exactly RES sclk periods in SPI mode 0: sclk idles at 0, mosi changes on the falling edge, MSB first, and miso is sampled on the rising edge. A configuration frame carries the 14-bit word shifted left by RES-14.
- R4: Between the rise of csN that ends one frame and the fall of csN that starts the next, at least GAP_NS worth of system clocks elapse (400 cycles at 200 MHz for 2000 ns).
- R5: A read whose channel differs from the tracked channel issues three frames: the updated configuration twice, then a frame of all zeros.
- R6: A read of the tracked channel issues two frames: the configuration once, then the all-zero frame.
- R7: A read changes only bits 9:7 (the channel field) of the shadow. The other 11 bits are sent as they were.
- R8: A raw write (reqWrite=1) replaces all 14 shadow bits and sends them in a single frame, followed by a done pulse. It does not change the tracked channel.
- R9: A read with reqChan >= NUM_CH is accepted and answered by an err pulse in the next cycle. It causes no frame, no done and no busy.
- R10: busy rises on the edge that accepts a valid request and falls on the edge that raises done. reqReady is 0 whenever busy is 1. done lasts one cycle.
- R11: On done after a read, sample holds the RES bits shifted in during the capture frame, MSB first. The tracked channel becomes the requested one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Block can accept a request |
| reqWrite | input | 1 | 1: raw configuration write, 0: channel read |
| reqChan | input | 3 | Channel to read |
| reqCfg | input | 14 | Configuration word for a raw write |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for an out-of-range channel |
| sample | output | RES | Last captured conversion |
| sclk | output | 1 | SPI clock |
| csN | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to converter |
| miso | input | 1 | SPI data from converter |

## Verification
The bench builds the block with NUM_CH=4, RES=16, CLK_DIV=2 and the default 200 MHz / 2000 ns gap. Using 16-bit frames with a 14-bit configuration exercises the two-bit left shift. The converter model checks the shift by recovering the configuration word from the frame it receives. Four channels behind a 3-bit request field mean that codes 4 to 7 exist, so the out-of-range path can be driven. A small divider keeps each frame short next to the 400-cycle gap, so the gap bound dominates the timing the bench measures. The converter model applies the two-frame lag itself and changes its data seed for every request, so a stale or wrong-channel sample is visible at the sample port.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int CFG_W    = 14;
  localparam int CHAN_LSB = 7;
  localparam int CHAN_W   = 3;
  localparam logic [CFG_W-1:0] BOOT_CFG = 14'h3C79;

  typedef enum logic [2:0] {
    ST_BOOT, ST_IDLE, ST_PREP, ST_SEND, ST_XFER, ST_GAP
  } seqState_t;

  typedef enum logic {JOB_RAW, JOB_READ} job_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadInit;
    logic loadRaw;
    logic loadChan;
    logic startFrame;
    logic sendZero;
    logic latchSample;
  } dpStrobe_t;
endpackage

// File: rtl/adcseq_dp.sv
module adcseq_dp
  import adcseq_pkg::*;
#(
  parameter int RES     = 16,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [CFG_W-1:0]  rawCfg,
  input  logic [CHAN_W-1:0] chanSel,
  input  logic              miso,
  output logic              sclk,
  output logic              csN,
  output logic              mosi,
  output logic              frameDone,
  output logic [RES-1:0]    sample
);
  localparam int SHIFT = RES - CFG_W;
  localparam int DIV_W = $clog2(CLK_DIV) + 1;
  localparam int BIT_W = $clog2(RES);

  logic [CFG_W-1:0] shadow;
  logic [RES-1:0]   txWord, txSh, rxSh;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             active;

  // shadow configuration: full replace or channel field only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadow <= '0;
    end else if (stb.loadInit) begin
      shadow <= BOOT_CFG;
    end else if (stb.loadRaw) begin
      shadow <= rawCfg;
    end else if (stb.loadChan) begin
      shadow[CHAN_LSB +: CHAN_W] <= chanSel;
    end
  end

  always_comb begin
    txWord = RES'(shadow) << SHIFT;
    if (stb.sendZero) txWord = '0;
  end

  // mode-0 shifter: rise samples, fall shifts
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      csN       <= 1'b1;
      sclk      <= 1'b0;
      txSh      <= '0;
      rxSh      <= '0;
      divCnt    <= '0;
      bitCnt    <= '0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      if (stb.startFrame) begin
        active <= 1'b1;
        csN    <= 1'b0;
        sclk   <= 1'b0;
        txSh   <= txWord;
        divCnt <= '0;
        bitCnt <= '0;
      end else if (active) begin
        if (divCnt == DIV_W'(CLK_DIV - 1)) begin
          divCnt <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            rxSh <= {rxSh[RES-2:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bitCnt == BIT_W'(RES - 1)) begin
              active    <= 1'b0;
              csN       <= 1'b1;
              frameDone <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 1'b1;
              txSh   <= txSh << 1;
            end
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  assign mosi = txSh[RES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sample <= '0;
    else if (stb.latchSample) sample <= rxSh;
  end
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int GAP_CYC = 400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [CHAN_W-1:0] reqChan,
  input  logic              frameDone,
  output dpStrobe_t         stb,
  output logic [CHAN_W-1:0] tgtChan,
  output logic              reqReady,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int GAP_W = $clog2(GAP_CYC + 1);

  seqState_t         state;
  job_t              job;
  logic              capStep, firstSent, initPhase;
  logic [1:0]        initLeft;
  logic [CHAN_W-1:0] curChan;
  logic [GAP_W-1:0]  gapCnt;
  logic              accept, gapEnd, badChan;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;
  assign gapEnd   = (state == ST_GAP) && (gapCnt == GAP_W'(GAP_CYC - 1));
  assign badChan  = ({1'b0, reqChan} >= (CHAN_W + 1)'(NUM_CH));

  always_comb begin
    stb             = '0;
    stb.loadInit    = (state == ST_BOOT);
    stb.loadRaw     = accept && reqWrite;
    stb.loadChan    = (state == ST_PREP);
    stb.startFrame  = (state == ST_SEND);
    stb.sendZero    = capStep;
    stb.latchSample = gapEnd && (job == JOB_READ) && capStep;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_BOOT;
      job       <= JOB_RAW;
      capStep   <= 1'b0;
      firstSent <= 1'b0;
      initPhase <= 1'b1;
      initLeft  <= '0;
      tgtChan   <= '0;
      curChan   <= '0;
      gapCnt    <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        ST_BOOT: begin
          job     <= JOB_RAW;
          capStep <= 1'b0;
          state   <= ST_SEND;
        end
        ST_IDLE: begin
          if (accept) begin
            if (reqWrite) begin
              job     <= JOB_RAW;
              capStep <= 1'b0;
              busy    <= 1'b1;
              state   <= ST_SEND;
            end else if (badChan) begin
              err <= 1'b1;
            end else begin
              tgtChan   <= reqChan;
              job       <= JOB_READ;
              capStep   <= 1'b0;
              firstSent <= 1'b0;
              busy      <= 1'b1;
              state     <= ST_PREP;
            end
          end
        end
        ST_PREP: state <= ST_SEND;
        ST_SEND: state <= ST_XFER;
        ST_XFER: begin
          if (frameDone) begin
            gapCnt <= '0;
            state  <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (!gapEnd) begin
            gapCnt <= gapCnt + 1'b1;
          end else if (job == JOB_RAW) begin
            if (initPhase) begin
              job       <= JOB_READ;
              tgtChan   <= '0;
              capStep   <= 1'b0;
              firstSent <= 1'b0;
              initLeft  <= 2'd2;
              state     <= ST_PREP;
            end else begin
              done  <= 1'b1;
              busy  <= 1'b0;
              state <= ST_IDLE;
            end
          end else if (!capStep) begin
            firstSent <= 1'b1;
            capStep   <= firstSent || (tgtChan == curChan);
            state     <= ST_SEND;
          end else begin
            curChan <= tgtChan;
            if (initPhase && initLeft != 2'd1) begin
              initLeft  <= initLeft - 1'b1;
              capStep   <= 1'b0;
              firstSent <= 1'b0;
              state     <= ST_PREP;
            end else if (initPhase) begin
              initPhase <= 1'b0;
              state     <= ST_IDLE;
            end else begin
              done  <= 1'b1;
              busy  <= 1'b0;
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adcseq.sv
module adcseq
  import adcseq_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int RES     = 16,
  parameter int CLK_DIV = 4,
  parameter int CLK_HZ  = 200_000_000,
  parameter int GAP_NS  = 2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [CHAN_W-1:0] reqChan,
  input  logic [CFG_W-1:0]  reqCfg,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [RES-1:0]    sample,
  output logic              sclk,
  output logic              csN,
  output logic              mosi,
  input  logic              miso
);
  localparam int GAP_RAW = ((CLK_HZ / 1000) * GAP_NS + 999_999) / 1_000_000;
  localparam int GAP_CYC = (GAP_RAW < 1) ? 1 : GAP_RAW;

  dpStrobe_t         stb;
  logic              frameDone;
  logic [CHAN_W-1:0] tgtChan;

  adcseq_ctrl #(.NUM_CH(NUM_CH), .GAP_CYC(GAP_CYC)) ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqChan(reqChan), .frameDone(frameDone), .stb(stb), .tgtChan(tgtChan),
    .reqReady(reqReady), .busy(busy), .done(done), .err(err)
  );

  adcseq_dp #(.RES(RES), .CLK_DIV(CLK_DIV)) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rawCfg(reqCfg), .chanSel(tgtChan),
    .miso(miso), .sclk(sclk), .csN(csN), .mosi(mosi),
    .frameDone(frameDone), .sample(sample)
  );
endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk #(
  parameter int RES     = 16,
  parameter int GAP_CYC = 400
) (
  input logic clk,
  input logic rstN,
  input logic reqReady,
  input logic busy,
  input logic done,
  input logic err,
  input logic sclk,
  input logic csN
);
  localparam int GAP_W  = $clog2(GAP_CYC + 2);
  localparam int RISE_W = $clog2(RES + 2);

  logic [GAP_W-1:0]  highCnt;
  logic [RISE_W-1:0] riseCnt;
  logic              sclkD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highCnt <= GAP_W'(GAP_CYC);
      riseCnt <= '0;
      sclkD   <= 1'b0;
    end else begin
      sclkD <= sclk;
      if (csN) begin
        if (highCnt < GAP_W'(GAP_CYC)) highCnt <= highCnt + 1'b1;
        riseCnt <= '0;
      end else begin
        highCnt <= '0;
        if (sclk && !sclkD) riseCnt <= riseCnt + 1'b1;
      end
    end
  end

  AST_IDLE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk); // R3
  AST_FRAME_BITS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> riseCnt == RISE_W'(RES)); // R3
  AST_QUIET_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> highCnt >= GAP_W'(GAP_CYC)); // R4
  AST_ERR_NO_WORK: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (csN && !busy && !done)); // R9
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !reqReady); // R10
  AST_BUSY_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
endmodule

bind adcseq adcseq_chk #(.RES(RES), .GAP_CYC(GAP_CYC)) chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .busy(busy), .done(done),
  .err(err), .sclk(sclk), .csN(csN)
);

// File: tb/adcseq_test.sv
`timescale 1ns/1ps
module adcseq_test;
  localparam int RES = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [2:0] reqChan = '0;
  logic [13:0] reqCfg = '0;
  logic reqReady, busy, done, err, sclk, csN, mosi;
  logic miso = 1'b0;
  logic [RES-1:0] sample;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  adcseq #(.NUM_CH(4), .RES(RES), .CLK_DIV(2), .CLK_HZ(200_000_000), .GAP_NS(2000)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqChan(reqChan), .reqCfg(reqCfg), .busy(busy),
    .done(done), .err(err), .sample(sample), .sclk(sclk), .csN(csN),
    .mosi(mosi), .miso(miso)
  );

  // converter model with two-frame configuration lag
  logic [12:0] seed = 13'h0123;
  logic [13:0] effCfg = '0, eff1 = '0, eff2 = '0;
  logic [RES-1:0] txW, rxW;
  logic [RES-1:0] hist [3];
  int frames = 0, bitRises = 0, badFrames = 0;
  int doneCnt = 0, hiRun = 0, minGap = 1_000_000;
  bit seenFrame = 0;

  function automatic logic [RES-1:0] dataOf(logic [12:0] s, logic [13:0] c);
    return {s, c[9:7]};
  endfunction

  always @(negedge csN) begin
    frames++;
    bitRises = 0;
    txW = dataOf(seed, eff2);
    miso = txW[RES-1];
  end
  always @(posedge sclk) if (!csN) begin
    rxW = {rxW[RES-2:0], mosi};
    bitRises++;
  end
  always @(negedge sclk) if (!csN) begin
    txW = txW << 1;
    miso = txW[RES-1];
  end
  always @(posedge csN) if (rstN) begin
    if (bitRises != RES) badFrames++;
    hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = rxW;
    eff2 = eff1;
    if (rxW[RES-1]) effCfg = rxW[RES-1:2];
    eff1 = effCfg;
    seenFrame = 1;
  end

  always @(posedge clk) begin
    if (csN) hiRun++;
    else begin
      if (seenFrame && hiRun > 0 && hiRun < minGap) minGap = hiRun;
      hiRun = 0;
    end
  end
  always @(negedge clk) if (done) doneCnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitDone(output bit seen);
    seen = 0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
  endtask

  task automatic issue(input bit wr, input logic [2:0] ch, input logic [13:0] cfg);
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqChan = ch; reqCfg = cfg;
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk(csN === 1 && sclk === 0 && done === 0 && err === 0 && busy === 0,
        "R1 outputs in reset", {csN, sclk, done, err, busy}, 5'b10000);
    rstN = 1;
    @(negedge clk);
    chk(reqReady === 0, "R1 not ready after reset", reqReady, 0);
    for (int i = 0; i < 20000 && !reqReady; i++) @(negedge clk);
    chk(frames == 5, "R2 start-up frame count", frames, 5);
    chk(doneCnt == 0, "R2 no done in start-up", doneCnt, 0);
    chk(hist[2] == 16'h0000 && hist[1] == (16'h3C79 << 2), "R2 start-up cfg word", hist[1], 16'h3C79 << 2);
    chk(sample == dataOf(seed, 14'h3C79), "R11 start-up sample", sample, dataOf(seed, 14'h3C79));
  endtask

  task automatic doRead(input logic [2:0] ch, input int expFrames, input logic [13:0] expCfg, input string req);
    bit seen;
    int f0 = frames;
    seed = seed + 13'h0A53;
    issue(0, ch, '0);
    chk(busy === 1 && reqReady === 0, "R10 busy after accept", {busy, reqReady}, 2'b10);
    waitDone(seen);
    chk(seen, "R10 done seen", seen, 1);
    chk(busy === 0, "R10 busy cleared at done", busy, 0);
    chk(frames - f0 == expFrames, req, frames - f0, expFrames);
    chk(hist[0] == '0, "R5 capture frame zero", hist[0], 0);
    chk(hist[1] == (RES'(expCfg) << 2), "R7 cfg word sent", hist[1], RES'(expCfg) << 2);
    if (expFrames == 3)
      chk(hist[2] == (RES'(expCfg) << 2), "R5 cfg sent twice", hist[2], RES'(expCfg) << 2);
    chk(sample == {seed, ch}, "R11 sample for channel", sample, {seed, ch});
    @(negedge clk);
    chk(done === 0, "R10 done single cycle", done, 0);
  endtask

  task automatic doRaw(input logic [13:0] cfg);
    bit seen;
    int f0 = frames;
    issue(1, 3'd0, cfg);
    chk(busy === 1, "R10 busy on raw write", busy, 1);
    waitDone(seen);
    chk(seen && frames - f0 == 1, "R8 raw write one frame", frames - f0, 1);
    chk(hist[0] == (RES'(cfg) << 2), "R8 raw word replaces all bits", hist[0], RES'(cfg) << 2);
  endtask

  task automatic doBad();
    int f0 = frames, d0 = doneCnt;
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqChan = 3'd5;
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
    chk(err === 1 && busy === 0 && reqReady === 1, "R9 err pulse", {err, busy, reqReady}, 3'b101);
    @(negedge clk);
    chk(err === 0, "R9 err one cycle", err, 0);
    repeat (600) @(negedge clk);
    chk(frames == f0 && doneCnt == d0, "R9 no frame no done", frames - f0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    doRead(3'd0, 2, 14'h3C79, "R6 same channel two frames");
    doRead(3'd2, 3, 14'h3D79, "R5 new channel three frames");
    doRead(3'd2, 2, 14'h3D79, "R6 repeat channel two frames");
    doRaw(14'h2DB5);
    doRead(3'd3, 3, 14'h2DB5, "R8 tracked channel kept by raw write");
    doRead(3'd1, 3, 14'h2CB5, "R7 field-only update");
    doBad();
    doRead(3'd3, 3, 14'h2DB5, "R5 highest channel");
    chk(badFrames == 0, "R3 bits per frame", badFrames, 0);
    chk(minGap >= 400, "R4 minimum idle gap", minGap, 400);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule